// File: doc/BRIEF.md
# Paged Monochrome LCD Frame Writer

This block sits behind a register write bus and turns command and data bytes for a 128x64 single-bit panel into the contents of a local 1024-byte video RAM. The panel is organised as eight horizontal pages of eight rows each. One byte covers one column of one page, and bit n of that byte is row n within the page. A mode register decides whether bytes arriving on the data port are taken as commands or as pixel data. Page-select commands pick the page that later data bytes fill, one column at a time.

Software selects a page, switches to data mode and then streams bytes. Each byte lands in the current column, and the column pointer advances and wraps inside the page. A separate scan port lets a display refresher fetch the state of any pixel. It presents (x, y) and gets the pixel bit back one cycle later.

Top module: `lcd_frame_writer`

## Requirements
- R1: A write to offset 0x1AC whose full 32-bit value is 0x00100011 puts the block in data mode. A write of 0x00104011 to the same offset puts it in command mode.
- R2: A write to offset 0x1AC of any other value puts the block in invalid mode. While in invalid mode, data-port writes change neither the video RAM nor the page or column.
- R3: A write to the instruction register at offset 0x1BC whose full 32-bit value lies in 0xB0..0xB7 selects page (value - 0xB0) and resets the column to 0. Any other value there has no effect.
- R4: In command mode, a data-port write (offset 0x1C0) of a value in 0xB0..0xB7 selects a page exactly as R3 does. Any other value has no effect, and nothing is stored.
- R5: In data mode, a data-port write stores bits [7:0] of the value at video RAM byte page*128 + column.
- R6: After each stored byte the column advances by one, modulo 128. Writing past column 127 continues at column 0 of the same page.
- R7: Pixel (x, y) is lit when bit (y mod 8) of byte x + (y/8)*128 is 1. scan_pix_o shows the pixel addressed by scan_x_i and scan_y_i at the previous rising clock edge.
- R8: Reset sets the mode to invalid, the page and the column to 0, and scan_pix_o to 0. Video RAM contents are not cleared.
- R9: Writes to any offset other than the three named ones have no effect.
- R10: When the scan port reads a byte that is being written at the same edge, it returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| wr_addr_i | input | 12 | Register byte offset |
| wr_data_i | input | 32 | Register write value |
| scan_x_i | input | 7 | Scan column, 0..127 |
| scan_y_i | input | 6 | Scan row, 0..63 |
| scan_pix_o | output | 1 | Pixel at the scan address, one cycle later |

## Verification
On every cycle the assertions check the cursor:
- a page select always leaves the column at 0 with the requested page;
- every accepted data byte moves the column by exactly one with wrap;
- in invalid mode, data-port writes leave the cursor alone;
- writes to unmapped offsets leave the mode, page and column unchanged.

Only the bench's scenarios can show that bytes land at the right video RAM address and that ignored writes leave memory untouched. The same holds for the read-before-write result at a colliding scan address and the pixel bit ordering across the whole frame. These come from the reference model's per-cycle comparison of scan_pix_o and a full-frame sweep.

// File: rtl/lcd_fw_pkg.sv
package lcd_fw_pkg;
  typedef enum logic [1:0] {
    MODE_INVALID = 2'd0,
    MODE_CMD     = 2'd1,
    MODE_DATA    = 2'd2
  } lcd_mode_e;
endpackage

// File: rtl/lcd_fw_decode.sv
module lcd_fw_decode
  import lcd_fw_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter int          DATA_W      = 32,
  parameter int          PAGES       = 8,
  parameter int          BYTE_W      = 8,
  parameter logic [11:0] OFS_MODE    = 12'h1AC,
  parameter logic [11:0] OFS_INSTR   = 12'h1BC,
  parameter logic [11:0] OFS_DATA    = 12'h1C0,
  parameter logic [31:0] WORD_DATA   = 32'h0010_0011,
  parameter logic [31:0] WORD_CMD    = 32'h0010_4011,
  parameter logic [31:0] PAGE_BASE   = 32'h0000_00B0,
  localparam int         PAGE_W      = $clog2(PAGES)
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  lcd_mode_e         mode_i,
  output logic              mode_wr_o,
  output lcd_mode_e         mode_nxt_o,
  output logic              page_sel_o,
  output logic [PAGE_W-1:0] page_nxt_o,
  output logic              store_o,
  output logic [BYTE_W-1:0] store_byte_o
);
  localparam logic [DATA_W-1:0] PAGE_LO = DATA_W'(PAGE_BASE);
  localparam logic [DATA_W-1:0] PAGE_HI = DATA_W'(PAGE_BASE) + DATA_W'(PAGES);

  logic hit_mode, hit_instr, hit_data, page_word;
  logic [DATA_W-1:0] page_off;

  assign hit_mode  = wr_en_i && (wr_addr_i == ADDR_W'(OFS_MODE));
  assign hit_instr = wr_en_i && (wr_addr_i == ADDR_W'(OFS_INSTR));
  assign hit_data  = wr_en_i && (wr_addr_i == ADDR_W'(OFS_DATA));

  // full-word range compare: upper bits must be zero
  assign page_word = (wr_data_i >= PAGE_LO) && (wr_data_i < PAGE_HI);
  assign page_off  = wr_data_i - PAGE_LO;

  always_comb begin
    mode_wr_o  = hit_mode;
    if (wr_data_i == DATA_W'(WORD_DATA))     mode_nxt_o = MODE_DATA;
    else if (wr_data_i == DATA_W'(WORD_CMD)) mode_nxt_o = MODE_CMD;
    else                                     mode_nxt_o = MODE_INVALID;
  end

  assign page_sel_o   = page_word && (hit_instr || (hit_data && mode_i == MODE_CMD));
  assign page_nxt_o   = page_off[PAGE_W-1:0];
  assign store_o      = hit_data && (mode_i == MODE_DATA);
  assign store_byte_o = wr_data_i[BYTE_W-1:0];
endmodule

// File: rtl/lcd_fw_cursor.sv
module lcd_fw_cursor
  import lcd_fw_pkg::*;
#(
  parameter int  COLS   = 128,
  parameter int  PAGES  = 8,
  localparam int COL_W  = $clog2(COLS),
  localparam int PAGE_W = $clog2(PAGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_wr_i,
  input  lcd_mode_e         mode_nxt_i,
  input  logic              page_sel_i,
  input  logic [PAGE_W-1:0] page_nxt_i,
  input  logic              store_i,
  output lcd_mode_e         mode_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [COL_W-1:0]  col_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= MODE_INVALID;
    end else if (mode_wr_i) begin
      mode_o <= mode_nxt_i;
    end
  end

  // page select and store are mutually exclusive by mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_o <= '0;
      col_o  <= '0;
    end else if (page_sel_i) begin
      page_o <= page_nxt_i;
      col_o  <= '0;
    end else if (store_i) begin
      col_o  <= col_o + COL_W'(1);
    end
  end
endmodule

// File: rtl/lcd_fw_vram.sv
module lcd_fw_vram #(
  parameter int  COLS   = 128,
  parameter int  PAGES  = 8,
  parameter int  BYTE_W = 8,
  localparam int COL_W  = $clog2(COLS),
  localparam int PAGE_W = $clog2(PAGES),
  localparam int BIT_W  = $clog2(BYTE_W),
  localparam int DEPTH  = COLS * PAGES,
  localparam int AW     = $clog2(DEPTH),
  localparam int Y_W    = PAGE_W + BIT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PAGE_W-1:0] wpage_i,
  input  logic [COL_W-1:0]  wcol_i,
  input  logic [BYTE_W-1:0] wbyte_i,
  input  logic [COL_W-1:0]  scan_x_i,
  input  logic [Y_W-1:0]    scan_y_i,
  output logic              pix_o
);
  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     waddr, raddr;
  logic [BYTE_W-1:0] rbyte;

  assign waddr = {wpage_i, wcol_i};
  assign raddr = {scan_y_i[Y_W-1:BIT_W], scan_x_i};
  assign rbyte = mem_q[raddr];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr] <= wbyte_i;
  end

  // read before write: rbyte is the pre-edge content
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pix_o <= 1'b0;
    else         pix_o <= rbyte[scan_y_i[BIT_W-1:0]];
  end
endmodule

// File: rtl/lcd_frame_writer.sv
module lcd_frame_writer
  import lcd_fw_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          DATA_W    = 32,
  parameter int          COLS      = 128,
  parameter int          PAGES     = 8,
  parameter int          BYTE_W    = 8,
  parameter logic [11:0] OFS_MODE  = 12'h1AC,
  parameter logic [11:0] OFS_INSTR = 12'h1BC,
  parameter logic [11:0] OFS_DATA  = 12'h1C0,
  parameter logic [31:0] WORD_DATA = 32'h0010_0011,
  parameter logic [31:0] WORD_CMD  = 32'h0010_4011,
  parameter logic [31:0] PAGE_BASE = 32'h0000_00B0,
  localparam int         COL_W     = $clog2(COLS),
  localparam int         PAGE_W    = $clog2(PAGES),
  localparam int         Y_W       = PAGE_W + $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [COL_W-1:0]  scan_x_i,
  input  logic [Y_W-1:0]    scan_y_i,
  output logic              scan_pix_o
);
  lcd_mode_e         mode_q, mode_nxt;
  logic              mode_wr, page_sel, store;
  logic [PAGE_W-1:0] page_q, page_nxt;
  logic [COL_W-1:0]  col_q;
  logic [BYTE_W-1:0] store_byte;

  lcd_fw_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGES(PAGES), .BYTE_W(BYTE_W),
    .OFS_MODE(OFS_MODE), .OFS_INSTR(OFS_INSTR), .OFS_DATA(OFS_DATA),
    .WORD_DATA(WORD_DATA), .WORD_CMD(WORD_CMD), .PAGE_BASE(PAGE_BASE)
  ) u_decode (
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .mode_i      (mode_q),
    .mode_wr_o   (mode_wr),
    .mode_nxt_o  (mode_nxt),
    .page_sel_o  (page_sel),
    .page_nxt_o  (page_nxt),
    .store_o     (store),
    .store_byte_o(store_byte)
  );

  lcd_fw_cursor #(.COLS(COLS), .PAGES(PAGES)) u_cursor (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_wr_i (mode_wr),
    .mode_nxt_i(mode_nxt),
    .page_sel_i(page_sel),
    .page_nxt_i(page_nxt),
    .store_i   (store),
    .mode_o    (mode_q),
    .page_o    (page_q),
    .col_o     (col_q)
  );

  lcd_fw_vram #(.COLS(COLS), .PAGES(PAGES), .BYTE_W(BYTE_W)) u_vram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (store),
    .wpage_i (page_q),
    .wcol_i  (col_q),
    .wbyte_i (store_byte),
    .scan_x_i(scan_x_i),
    .scan_y_i(scan_y_i),
    .pix_o   (scan_pix_o)
  );
endmodule

// File: rtl/lcd_fw_checker.sv
module lcd_fw_checker
  import lcd_fw_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          DATA_W    = 32,
  parameter int          COL_W     = 7,
  parameter int          PAGE_W    = 3,
  parameter int          PAGES     = 8,
  parameter logic [11:0] OFS_MODE  = 12'h1AC,
  parameter logic [11:0] OFS_INSTR = 12'h1BC,
  parameter logic [11:0] OFS_DATA  = 12'h1C0,
  parameter logic [31:0] PAGE_BASE = 32'h0000_00B0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input lcd_mode_e         mode_q,
  input logic [PAGE_W-1:0] page_q,
  input logic [COL_W-1:0]  col_q
);
  logic to_data, to_instr, unmapped, page_word;
  assign to_data   = wr_en_i && wr_addr_i == ADDR_W'(OFS_DATA);
  assign to_instr  = wr_en_i && wr_addr_i == ADDR_W'(OFS_INSTR);
  assign unmapped  = wr_en_i && !to_data && !to_instr && wr_addr_i != ADDR_W'(OFS_MODE);
  assign page_word = wr_data_i >= DATA_W'(PAGE_BASE) &&
                     wr_data_i <  DATA_W'(PAGE_BASE) + DATA_W'(PAGES);

  // R3: instruction page select lands on requested page, column 0
  p_instr_page_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_instr && page_word) |=> (col_q == '0 &&
      page_q == PAGE_W'($past(wr_data_i) - DATA_W'(PAGE_BASE))));

  // R4: command-mode data write selects page the same way
  p_cmd_page_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_data && mode_q == MODE_CMD && page_word) |=> (col_q == '0));

  // R6: each stored byte advances the column by one with wrap
  p_col_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_data && mode_q == MODE_DATA) |=>
      (col_q == COL_W'($past(col_q) + COL_W'(1)) && $stable(page_q)));

  // R2: data port inert in invalid mode
  p_invalid_inert_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_data && mode_q == MODE_INVALID) |=> ($stable(col_q) && $stable(page_q)));

  // R9: unmapped offsets touch no state
  p_unmapped_inert_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped |=> ($stable(col_q) && $stable(page_q) && $stable(mode_q)));
endmodule

bind lcd_frame_writer lcd_fw_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W), .PAGE_W(PAGE_W), .PAGES(PAGES),
  .OFS_MODE(OFS_MODE), .OFS_INSTR(OFS_INSTR), .OFS_DATA(OFS_DATA), .PAGE_BASE(PAGE_BASE)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i),
  .mode_q   (mode_q),
  .page_q   (page_q),
  .col_q    (col_q)
);

// File: tb/sim_lcd_frame_writer.sv
`timescale 1ns/1ps
module sim_lcd_frame_writer;
  localparam logic [11:0] A_MODE  = 12'h1AC;
  localparam logic [11:0] A_INSTR = 12'h1BC;
  localparam logic [11:0] A_DATA  = 12'h1C0;
  localparam logic [31:0] W_DATA  = 32'h0010_0011;
  localparam logic [31:0] W_CMD   = 32'h0010_4011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [6:0]  sx = '0;
  logic [5:0]  sy = '0;
  logic        pix;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string cur_req = "R8";

  always #2.5 clk = ~clk;

  lcd_frame_writer u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .scan_x_i(sx), .scan_y_i(sy), .scan_pix_o(pix)
  );

  // reference model: 0 invalid, 1 command, 2 data
  byte unsigned mem_m [1024];
  bit           known_m [1024];
  int           mode_m = 0, page_m = 0, col_m = 0;
  bit           exp_pix = 0, exp_valid = 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_m = 0; page_m = 0; col_m = 0; exp_pix = 0; exp_valid = 1;
    end else begin
      int idx;
      idx = int'(sx) + (int'(sy) / 8) * 128;
      exp_valid = known_m[idx];
      exp_pix   = mem_m[idx][sy % 8];
      if (wr_en) begin
        if (wr_addr == A_MODE)
          mode_m = (wr_data == W_DATA) ? 2 : (wr_data == W_CMD) ? 1 : 0;
        else if (wr_addr == A_INSTR || (wr_addr == A_DATA && mode_m == 1)) begin
          if (wr_data >= 32'hB0 && wr_data <= 32'hB7) begin
            page_m = int'(wr_data) - 'hB0; col_m = 0;
          end
        end else if (wr_addr == A_DATA && mode_m == 2) begin
          mem_m[page_m * 128 + col_m]   = wr_data[7:0];
          known_m[page_m * 128 + col_m] = 1;
          col_m = (col_m + 1) % 128;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done && exp_valid) begin
      checks++;
      if (pix !== exp_pix) begin
        failures++;
        $display("FAIL %s pixel x=%0d y=%0d actual=%0b expected=%0b",
                 cur_req, sx, sy, pix, exp_pix);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic scan_byte(input int page, input int col);
    for (int b = 0; b < 8; b++) begin
      @(negedge clk); sx = 7'(col); sy = 6'(page * 8 + b);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; failures++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R8: output held at 0 in reset
    repeat (3) @(negedge clk);
    checks++;
    if (pix !== 1'b0) begin
      failures++; $display("FAIL R8 reset pix actual=%0b expected=0", pix);
    end
    rst_n = 1;

    // R1 / R3: clear every page through data mode
    cur_req = "R1";
    wr(A_MODE, W_DATA);
    for (int p = 0; p < 8; p++) begin
      wr(A_INSTR, 32'hB0 + 32'(p));
      for (int c = 0; c < 128; c++) wr(A_DATA, 32'h0);
    end

    // R8: reset leaves mode invalid, page/column 0
    cur_req = "R8";
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    wr(A_DATA, 32'hFF);
    scan_byte(0, 0);
    wr(A_MODE, W_DATA);
    wr(A_DATA, 32'h81);
    scan_byte(0, 0);

    // R5: data stored at page*128+column
    cur_req = "R5";
    wr(A_INSTR, 32'hB3);
    wr(A_DATA, 32'hA5);
    wr(A_DATA, 32'h3C);
    scan_byte(3, 0); scan_byte(3, 1);

    // R6: wrap past column 127 stays in page
    cur_req = "R6";
    wr(A_INSTR, 32'hB5);
    for (int c = 0; c < 130; c++) wr(A_DATA, 32'(c + 1));
    scan_byte(5, 0); scan_byte(5, 1); scan_byte(5, 127); scan_byte(6, 0);

    // R4: page select via data port in command mode
    cur_req = "R4";
    wr(A_MODE, W_CMD);
    wr(A_DATA, 32'hB2);
    wr(A_DATA, 32'h55);
    scan_byte(2, 0);
    wr(A_MODE, W_DATA);
    wr(A_DATA, 32'h77);
    scan_byte(2, 0); scan_byte(2, 1);

    // R3: out-of-range instruction values ignored
    cur_req = "R3";
    wr(A_INSTR, 32'hB8);
    wr(A_INSTR, 32'hAF);
    wr(A_INSTR, 32'h1B1);
    wr(A_DATA, 32'hE7);
    scan_byte(2, 2); scan_byte(1, 0);
    wr(A_INSTR, 32'hB7);
    wr(A_DATA, 32'h18);
    scan_byte(7, 0);

    // R2: any other mode word is invalid
    cur_req = "R2";
    wr(A_MODE, 32'h0010_0012);
    wr(A_DATA, 32'hFF);
    scan_byte(7, 1);
    wr(A_MODE, W_DATA);
    wr(A_DATA, 32'h42);
    scan_byte(7, 1); scan_byte(7, 2);

    // R9: unmapped offset ignored
    cur_req = "R9";
    wr(12'h1C4, 32'hFF);
    wr(12'h1B0, 32'hB4);
    scan_byte(7, 2);
    wr(A_DATA, 32'h24);
    scan_byte(7, 2); scan_byte(4, 0);

    // R10: scan and write the same byte at one edge
    cur_req = "R10";
    wr(A_INSTR, 32'hB6);
    @(negedge clk); sx = 7'd0; sy = 6'd48;
    wr(A_DATA, 32'h01);
    @(negedge clk);
    @(negedge clk);

    // R7: full-frame sweep
    cur_req = "R7";
    for (int y = 0; y < 64; y++)
      for (int x = 0; x < 128; x++) begin
        @(negedge clk); sx = 7'(x); sy = 6'(y);
      end
    @(negedge clk); @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule